// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects level-sensitive interrupt requests from a large set of sources and presents them to a processor on two outputs: a normal request line and a fast request line. Each source's request is the OR of its hardware input and a software-trigger bit. A per-source mask bit can block it. A per-source level register gives it a 6-bit priority and chooses which of the two outputs it competes for.

For each output, a small state machine with two states, `ARB_IDLE` and `ARB_HOLD`, runs its own arbitration. In `ARB_IDLE` it looks for the best eligible request. That is the lowest priority value, with ties going to the lower source number, among sources that pass a global threshold. When a candidate exists, the `GRANT` transition latches its number and priority, enters `ARB_HOLD` and asserts the output. The output and the latched values stay fixed until software writes the matching acknowledge bit. That is the `RELEASE` transition back to `ARB_IDLE`, after which arbitration runs again. Reading the winner while nothing is held returns a spurious flag.

Software reaches everything through one 32-bit register port with a word address. Writes take effect at the clock edge and reads are combinational. Sources are grouped in banks of 32: source n is bit (n mod 32) of bank (n div 32). The sources, banks and priority widths are parameters; the address map below assumes the defaults of 128 sources in 4 banks.

Top module: `prio_intc`

## Requirements
- R1: After reset, both outputs are low, every mask bit is 1, every software-trigger bit and level register is 0, and the threshold register (address 0x01) reads 0xFF.
- R2: Each bank b has a mask register at 0x10+8b+1. A 1 written to a bit of mask-clear (0x10+8b+2) clears that mask bit, and a 1 written to mask-set (0x10+8b+3) sets it. Zero bits written change nothing. A source whose mask bit is 1 never reaches either output.
- R3: Writing 1 to a bit of software-set (0x10+8b+4) sets that trigger bit, and the same address reads back all trigger bits. Writing 1 to software-clear (0x10+8b+5) clears the bit. A set trigger bit requests exactly as a high hardware input does.
- R4: The raw register (0x10+8b+0) shows the hardware inputs before masking. Pending-normal (0x10+8b+6) and pending-fast (0x10+8b+7) show the unmasked requests steered to each output.
- R5: The level register of source n is at 0x80+n. Bit 0 selects the output (0 = normal, 1 = fast), bits 7:2 hold the priority, and the register reads back as written in those bits.
- R6: Among eligible requests for one output, the lowest priority value wins and equal values go to the lower source number. The output rises at the clock edge after the first edge at which a candidate is eligible.
- R7: While an output is high, its winning number and priority stay fixed, even if a better request appears. Writing address 0x00 with bit 0 set drops the normal output, and with bit 1 set drops the fast output. The other output is unaffected, and arbitration restarts on the next edge.
- R8: When the threshold is not 0xFF, a source takes part only if its priority value is strictly less than the threshold.
- R9: The normal winner number reads at 0x02 in bits 6:0 and its priority at 0x03 in bits 5:0. The fast winner number reads at 0x04 and its priority at 0x05. While the matching output is low, these read as 0x80000000 (bit 31 is the spurious flag).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive hardware requests |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The hardest situation to create is a held winner being overtaken by a better request. The output must not change, and the new source must win only after the acknowledge. The stimulus latches a mid-priority source, then raises a source with priority 0 while the output is held, and reads the winner both before and after the acknowledge. Ties are also hard to reach, because they need two sources with equal priority in different banks to be pending at the same edge. The bench programs their level registers first and then raises both inputs in the same cycle. A sweep over every source number confirms the bank and bit mapping end to end.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int DATA_W      = 32;
    localparam int THR_W       = 8;
    localparam int THR_OFF     = 255;
    localparam int A_ACK       = 'h00;
    localparam int A_THR       = 'h01;
    localparam int A_IRQ_NUM   = 'h02;
    localparam int A_IRQ_PRI   = 'h03;
    localparam int A_FIQ_NUM   = 'h04;
    localparam int A_FIQ_PRI   = 'h05;
    localparam int A_BANK_BASE = 'h10;
    localparam int A_LVL_BASE  = 'h80;
    localparam int BANK_SPAN   = 8;

    typedef enum logic [2:0] {
        SLOT_RAW   = 3'd0,
        SLOT_MASK  = 3'd1,
        SLOT_MCLR  = 3'd2,
        SLOT_MSET  = 3'd3,
        SLOT_SWSET = 3'd4,
        SLOT_SWCLR = 3'd5,
        SLOT_PIRQ  = 3'd6,
        SLOT_PFIQ  = 3'd7
    } bank_slot_e;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] raw_i,
    input  logic [DATA_W-1:0] steer_i,
    input  logic              wr_i,
    input  logic [2:0]        slot_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] req_irq_o,
    output logic [DATA_W-1:0] req_fiq_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] sw_q;
    logic [DATA_W-1:0] live;
    bank_slot_e        slot;

    assign slot = bank_slot_e'(slot_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            sw_q   <= '0;
        end else if (wr_i) begin
            if (slot == SLOT_MCLR)  mask_q <= mask_q & ~wdata_i;
            if (slot == SLOT_MSET)  mask_q <= mask_q | wdata_i;
            if (slot == SLOT_SWSET) sw_q   <= sw_q | wdata_i;
            if (slot == SLOT_SWCLR) sw_q   <= sw_q & ~wdata_i;
        end
    end

    assign live      = (raw_i | sw_q) & ~mask_q;
    assign req_irq_o = live & ~steer_i;
    assign req_fiq_o = live & steer_i;

    always_comb begin
        unique case (slot)
            SLOT_RAW:   rdata_o = raw_i;
            SLOT_MASK:  rdata_o = mask_q;
            SLOT_SWSET: rdata_o = sw_q;
            SLOT_PIRQ:  rdata_o = req_irq_o;
            SLOT_PFIQ:  rdata_o = req_fiq_o;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N      = 128,
    parameter int PRIO_W = 6,
    parameter int IDX_W  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    input  logic [THR_W-1:0]    thr_i,
    input  logic                ack_i,
    output logic                held_o,
    output logic [IDX_W-1:0]    num_o,
    output logic [PRIO_W-1:0]   pri_o
);
    arb_state_e        state_q, state_d;
    logic              found;
    logic [IDX_W-1:0]  best_i;
    logic [PRIO_W-1:0] best_p;

    // Ascending scan with strict compare: ties keep the lower index.
    always_comb begin
        found  = 1'b0;
        best_i = '0;
        best_p = '1;
        for (int i = 0; i < N; i++) begin
            logic [PRIO_W-1:0] p;
            logic              pass;
            p    = prio_i[i*PRIO_W +: PRIO_W];
            pass = req_i[i] && ((int'(thr_i) == THR_OFF) || (int'(p) < int'(thr_i)));
            if (pass && (!found || p < best_p)) begin
                found  = 1'b1;
                best_p = p;
                best_i = IDX_W'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (found) state_d = ARB_HOLD;  // GRANT
            ARB_HOLD: if (ack_i) state_d = ARB_IDLE;  // RELEASE
            default:  state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_o <= '0;
            pri_o <= '0;
        end else if (state_q == ARB_IDLE && found) begin
            num_o <= best_i;
            pri_o <= best_p;
        end
    end

    assign held_o = (state_q == ARB_HOLD);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int PRIO_W  = 6,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int NUM_BANKS = NUM_SRC / DATA_W;
    localparam int IDX_W     = $clog2(NUM_SRC);

    logic [THR_W-1:0]             thr_q;
    logic [NUM_SRC-1:0]           steer_q;
    logic [PRIO_W-1:0]            prio_q [NUM_SRC];
    logic [NUM_SRC*PRIO_W-1:0]    prio_flat;
    logic [NUM_SRC-1:0]           req_irq, req_fiq;
    logic [DATA_W-1:0]            bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0]         bank_sel;
    logic [1:0]                   ack;
    logic [1:0]                   held;
    logic [1:0][IDX_W-1:0]        act_num;
    logic [1:0][PRIO_W-1:0]       act_pri;
    logic [ADDR_W-1:0]            bank_off, lvl_off;
    logic                         bank_hit, lvl_hit;

    assign bank_off = bus_addr - ADDR_W'(A_BANK_BASE);
    assign lvl_off  = bus_addr - ADDR_W'(A_LVL_BASE);
    assign bank_hit = (bus_addr >= ADDR_W'(A_BANK_BASE)) &&
                      (int'(bank_off) < NUM_BANKS * BANK_SPAN);
    assign lvl_hit  = (bus_addr >= ADDR_W'(A_LVL_BASE)) && (int'(lvl_off) < NUM_SRC);

    assign ack[0] = bus_we && bus_addr == ADDR_W'(A_ACK) && bus_wdata[0];
    assign ack[1] = bus_we && bus_addr == ADDR_W'(A_ACK) && bus_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      thr_q <= THR_W'(THR_OFF);
        else if (bus_we && bus_addr == ADDR_W'(A_THR))   thr_q <= bus_wdata[THR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steer_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
        end else if (bus_we && lvl_hit) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (lvl_off == ADDR_W'(i)) begin
                    steer_q[i] <= bus_wdata[0];
                    prio_q[i]  <= bus_wdata[2 +: PRIO_W];
                end
            end
        end
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_flat
            assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
        end

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_sel[b] = bank_hit &&
                (int'(bank_off[ADDR_W-1:3]) == b);
            intc_bank u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .raw_i     (src_i[b*DATA_W +: DATA_W]),
                .steer_i   (steer_q[b*DATA_W +: DATA_W]),
                .wr_i      (bus_we && bank_sel[b]),
                .slot_i    (bank_off[2:0]),
                .wdata_i   (bus_wdata),
                .req_irq_o (req_irq[b*DATA_W +: DATA_W]),
                .req_fiq_o (req_fiq[b*DATA_W +: DATA_W]),
                .rdata_o   (bank_rd[b])
            );
        end

        for (genvar k = 0; k < 2; k++) begin : g_arb
            intc_arbiter #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_i  ((k == 0) ? req_irq : req_fiq),
                .prio_i (prio_flat),
                .thr_i  (thr_q),
                .ack_i  (ack[k]),
                .held_o (held[k]),
                .num_o  (act_num[k]),
                .pri_o  (act_pri[k])
            );
        end
    endgenerate

    assign irq_o = held[0];
    assign fiq_o = held[1];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_THR))
            bus_rdata = {{(DATA_W-THR_W){1'b0}}, thr_q};
        else if (bus_addr == ADDR_W'(A_IRQ_NUM))
            bus_rdata = held[0] ? {{(DATA_W-IDX_W){1'b0}}, act_num[0]} : 32'h8000_0000;
        else if (bus_addr == ADDR_W'(A_IRQ_PRI))
            bus_rdata = held[0] ? {{(DATA_W-PRIO_W){1'b0}}, act_pri[0]} : 32'h8000_0000;
        else if (bus_addr == ADDR_W'(A_FIQ_NUM))
            bus_rdata = held[1] ? {{(DATA_W-IDX_W){1'b0}}, act_num[1]} : 32'h8000_0000;
        else if (bus_addr == ADDR_W'(A_FIQ_PRI))
            bus_rdata = held[1] ? {{(DATA_W-PRIO_W){1'b0}}, act_pri[1]} : 32'h8000_0000;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_sel[b]) bus_rdata = bank_rd[b];
        if (lvl_hit) begin
            for (int i = 0; i < NUM_SRC; i++)
                if (lvl_off == ADDR_W'(i))
                    bus_rdata = {{(DATA_W-PRIO_W-2){1'b0}}, prio_q[i], 1'b0, steer_q[i]};
        end
    end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 7,
    parameter int PRIO_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              fiq_o,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [THR_W-1:0]  thr,
    input logic [IDX_W-1:0]  irq_num,
    input logic [PRIO_W-1:0] irq_pri,
    input logic [IDX_W-1:0]  fiq_num
);
    logic ack_n, ack_f;
    assign ack_n = bus_we && bus_addr == ADDR_W'(A_ACK) && bus_wdata[0];
    assign ack_f = bus_we && bus_addr == ADDR_W'(A_ACK) && bus_wdata[1];

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !ack_n |=> irq_o && $stable(irq_num) && $stable(irq_pri)); // R7
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && ack_n |=> !irq_o); // R7
    AST_FIQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o && !ack_f |=> fiq_o && $stable(fiq_num)); // R7
    AST_FIQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o && ack_f |=> !fiq_o); // R7
    AST_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && bus_addr == ADDR_W'(A_IRQ_NUM) |-> bus_rdata[31]); // R9
    AST_THRESHOLD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) && int'($past(thr)) != THR_OFF |-> int'(irq_pri) < int'($past(thr))); // R8
endmodule

bind prio_intc intc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .thr       (thr_q),
    .irq_num   (act_num[0]),
    .irq_pri   (act_pri[0]),
    .fiq_num   (act_num[1])
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    localparam int NS = 128;
    localparam logic [7:0] ACK = 8'h00, THR = 8'h01, INUM = 8'h02, IPRI = 8'h03;
    localparam logic [7:0] FNUM = 8'h04, FPRI = 8'h05;
    localparam logic [31:0] SPUR = 32'h8000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o, fiq_o;
    int            errs = 0, checks = 0, cyc = 0;

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [7:0] bank_a(int b, int slot);
        return 8'(16 + 8 * b + slot);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic chk_rd(string req, logic [7:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        wait (cyc > 150000);
        errs++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        summary();
    end

    initial begin
        wait_n(3);
        // R1: reset state
        chk("R1 irq_o", 32'(irq_o), 0);
        chk("R1 fiq_o", 32'(fiq_o), 0);
        rst_n = 1'b1;
        wait_n(1);
        for (int b = 0; b < 4; b++) chk_rd("R1 mask", bank_a(b, 1), 32'hFFFF_FFFF);
        chk_rd("R1 threshold", THR, 32'hFF);
        chk_rd("R1 level", 8'h85, 0);
        chk_rd("R1 sw", bank_a(2, 4), 0);
        chk_rd("R9 spurious at reset", INUM, SPUR);

        // R2: masked sources are blocked; R4: raw shows inputs
        src_i = '1;
        wait_n(3);
        chk("R2 masked output", 32'(irq_o), 0);
        chk_rd("R4 raw", bank_a(2, 0), 32'hFFFF_FFFF);
        chk_rd("R4 pending masked", bank_a(2, 6), 0);
        src_i = '0;
        wr(bank_a(1, 2), 0);
        chk_rd("R2 zero write ignored", bank_a(1, 1), 32'hFFFF_FFFF);
        for (int b = 0; b < 4; b++) wr(bank_a(b, 2), 32'hFFFF_FFFF);
        for (int b = 0; b < 4; b++) chk_rd("R2 mask cleared", bank_a(b, 1), 0);

        // R6 sweep: every source alone
        for (int n = 0; n < NS; n++) begin
            src_i = '0; src_i[n] = 1'b1;
            wait_n(3);
            chk("R6 sweep out", 32'(irq_o), 1);
            chk_rd("R6 sweep num", INUM, 32'(n));
            chk_rd("R5 sweep prio", IPRI, 0);
            chk_rd("R4 sweep pending", bank_a(n / 32, 6), 32'(1) << (n % 32));
            src_i = '0;
            wr(ACK, 1);
            wait_n(2);
            chk("R7 sweep release", 32'(irq_o), 0);
            chk_rd("R9 sweep spurious", INUM, SPUR);
        end

        // R6 priority and ties, R7 hold and re-arbitration
        wr(8'h85, 10 << 2);
        wr(8'h80 + 8'd70, 3 << 2);
        wr(8'h80 + 8'd100, 3 << 2);
        wait_n(1);
        src_i[5] = 1'b1; src_i[70] = 1'b1; src_i[100] = 1'b1;
        wait_n(3);
        chk_rd("R6 tie lower number", INUM, 70);
        chk_rd("R6 winner prio", IPRI, 3);
        src_i[2] = 1'b1;
        wait_n(3);
        chk_rd("R7 held despite better", INUM, 70);
        wr(ACK, 1); wait_n(2);
        chk_rd("R7 rearbitrate", INUM, 2);
        src_i[2] = 1'b0; wr(ACK, 1); wait_n(2);
        chk_rd("R6 next", INUM, 70);
        src_i[70] = 1'b0; wr(ACK, 1); wait_n(2);
        chk_rd("R6 next tie", INUM, 100);
        src_i[100] = 1'b0; wr(ACK, 1); wait_n(2);
        chk_rd("R6 last", INUM, 5);
        chk_rd("R5 prio field", IPRI, 10);

        // R8 threshold
        wr(THR, 10); wr(ACK, 1); wait_n(3);
        chk("R8 equal excluded", 32'(irq_o), 0);
        chk_rd("R8 spurious", INUM, SPUR);
        wr(THR, 11); wait_n(3);
        chk_rd("R8 below passes", INUM, 5);
        wr(THR, 0); wr(ACK, 1); wait_n(3);
        chk("R8 zero blocks", 32'(irq_o), 0);
        wr(THR, 8'hFF); wait_n(3);
        chk("R8 disabled", 32'(irq_o), 1);

        // R5 steering to the fast output
        wr(8'h80 + 8'd20, (2 << 2) | 1);
        src_i[20] = 1'b1;
        wait_n(3);
        chk("R5 fiq_o", 32'(fiq_o), 1);
        chk_rd("R9 fast num", FNUM, 20);
        chk_rd("R9 fast prio", FPRI, 2);
        chk_rd("R4 pending fast", bank_a(0, 7), 32'(1) << 20);
        chk_rd("R4 pending normal", bank_a(0, 6), 32'(1) << 5);
        chk_rd("R5 level readback", 8'h80 + 8'd20, 9);
        src_i[20] = 1'b0;
        wr(ACK, 2); wait_n(2);
        chk("R7 fast release", 32'(fiq_o), 0);
        chk("R7 normal unaffected", 32'(irq_o), 1);
        chk_rd("R9 fast spurious", FNUM, SPUR);
        src_i = '0; wr(ACK, 1); wait_n(2);

        // R3 software trigger
        wr(bank_a(1, 4), 32'(1) << 8);
        chk_rd("R3 sw readback", bank_a(1, 4), 32'(1) << 8);
        wait_n(2);
        chk_rd("R3 sw request", INUM, 40);
        wr(bank_a(1, 3), 32'(1) << 8);
        chk_rd("R2 mask set", bank_a(1, 1), 32'(1) << 8);
        chk_rd("R2 pending blocked", bank_a(1, 6), 0);
        wr(ACK, 1); wait_n(2);
        chk("R2 masked sw", 32'(irq_o), 0);
        wr(bank_a(1, 5), 32'(1) << 8);
        chk_rd("R3 sw cleared", bank_a(1, 4), 0);

        summary();
    end
endmodule